// File: doc/BRIEF.md
# Densely Packed Decimal Converter

This unit recodes decimal data held in a 64-bit register word in either direction between the compact 10-bit declet form of densely packed decimal and plain BCD, where every digit takes a 4-bit nibble. In the expanding direction each declet becomes three BCD digits (12 bits). In the compressing direction each 12-bit group of three nibbles folds back into one declet. Every 32-bit half of the word carries two such fields, so one operation converts four fields at once.

The recoding uses fixed Boolean equations. They are applied to every input pattern, including declets outside the canonical set and nibbles above 9, and nothing is trapped or flagged. A single select input picks the direction for each operation. The operand enters through a valid/ready handshake. The result is held in a register and is presented one cycle after the operand is accepted. It stays on the output until the consumer takes it.

Top module: `dpd_codec`

## Requirements
- R1: While rst_n is low and right after it is released, out_valid is 0, out_word is 0 and in_ready is 1.
- R2: With in_dir = 0 (expand), the declets at input bits [9:0], [19:10], [41:32] and [51:42] are converted to 12-bit BCD groups written to output bits [11:0], [23:12], [43:32] and [55:44], in that pairing. Within a group, bits [11:8] are the leading digit and bits [3:0] the last digit.
- R3: With in_dir = 1 (compress), the 12-bit groups at input bits [11:0], [23:12], [43:32] and [55:44] are converted to declets written to output bits [9:0], [19:10], [41:32] and [51:42], in that pairing.
- R4: The lowest bit of each digit passes through unchanged. Declet bits 7, 4 and 0 equal group bits 8, 4 and 0, in both directions.
- R5: Every output bit that lies outside the converted fields is 0, whatever the input carries there.
- R6: All 1024 declet values and all 4096 group values are accepted and converted by the same equations, with no special handling of non-canonical patterns.
- R7: An operand accepted at a clock edge (in_valid and in_ready both high) produces out_valid = 1 with its result at the next edge.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_word does not change.
- R9: in_ready is low while a result is waiting and out_ready is low. An operand offered in that state is not taken. A result taken with no new operand drops out_valid at the next edge.
- R10: In compress mode the indicator bit 3 of each declet is the OR of the three digit top bits of its group (group bits 11, 7 and 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operand is offered |
| in_ready | output | 1 | The unit can take an operand this cycle |
| in_dir | input | 1 | 0 = declet to BCD, 1 = BCD to declet |
| in_word | input | 64 | Operand word |
| out_valid | output | 1 | A result is waiting |
| out_ready | input | 1 | The consumer takes the result |
| out_word | output | 64 | Result word |

## Verification
The only result of this block, the converted word, is due exactly one edge after the edge that accepts the operand. The bench drives each operand on a falling edge and samples on the next falling edge. At that point out_valid and the whole 64-bit result must already match the bench's table-based model, with nothing waited for. Under backpressure the same word must still be present on every falling edge while out_ready stays low. The first falling edge after the result is released must show out_valid low, which proves the operand offered during the stall was dropped.

// File: rtl/dpd_codec_pkg.sv
package dpd_codec_pkg;

  localparam int DEC_W = 10;
  localparam int GRP_W = 12;

  typedef enum logic {
    DIR_EXPAND   = 1'b0,
    DIR_COMPRESS = 1'b1
  } dpd_dir_e;

  // declet (index 9 = most significant) to three BCD digits (index 11 = msb)
  function automatic logic [GRP_W-1:0] declet_expand(input logic [DEC_W-1:0] dc);
    logic [GRP_W-1:0] g;
    logic ind, s1, s0, k1, k0;
    ind = dc[3];
    s1  = dc[2];
    s0  = dc[1];
    k1  = dc[6];
    k0  = dc[5];
    g[11] = (ind & s1 & ~k1) | (ind & s1 & k1 & k0) | (ind & s1 & ~s0);
    g[10] = dc[9] & (~ind | ~s1 | (k1 & s0 & ~k0));
    g[9]  = dc[8] & (~ind | ~s1 | (k1 & s0 & ~k0));
    g[8]  = dc[7];
    g[7]  = (ind & ~s1 & s0) | (ind & s1 & s0 & (k1 | ~k0));
    g[6]  = (k1 & ~ind) | (k1 & ind & ~s0) | (dc[9] & ~k1 & k0 & ind & s1 & s0);
    g[5]  = (k0 & ~ind) | (k0 & ind & ~s0) | (dc[8] & ~k1 & k0 & ind & s1 & s0);
    g[4]  = dc[4];
    g[3]  = (ind & s1 & s0 & (k1 | k0)) | (ind & ~s1 & ~s0);
    g[2]  = (s1 & ~ind) | (ind & k1 & ~s1 & s0) | (ind & dc[9] & s1 & ~s0)
          | (ind & dc[9] & s1 & ~k1 & ~k0);
    g[1]  = (s0 & ~ind) | (ind & k0 & ~s1 & s0) | (ind & dc[8] & s1 & ~s0)
          | (ind & dc[8] & s1 & ~k1 & ~k0);
    g[0]  = dc[0];
    return g;
  endfunction

  // three BCD digits back into one declet
  function automatic logic [DEC_W-1:0] group_compress(input logic [GRP_W-1:0] g);
    logic [DEC_W-1:0] dc;
    logic ta, te, ti;
    ta = g[11];
    te = g[7];
    ti = g[3];
    dc[9] = (g[10] & ~ta) | (g[2] & ta & ~ti) | (g[6] & ta & ti & ~te);
    dc[8] = (g[9] & ~ta) | (g[1] & ta & ~ti) | (g[5] & ta & ti & ~te);
    dc[7] = g[8];
    dc[6] = (te & ti) | (g[6] & ~te & (~ti | ~ta)) | (g[2] & ~ta & te & ~ti);
    dc[5] = (ta & ti) | (g[5] & ~te & (~ti | ~ta)) | (g[1] & ~ta & te & ~ti);
    dc[4] = g[4];
    dc[3] = ta | te | ti;
    dc[2] = ta | (te & ti) | (g[2] & ~te & ~ti);
    dc[1] = te | (ta & ti) | (g[1] & ~ta & ~ti);
    dc[0] = g[0];
    return dc;
  endfunction

endpackage

// File: rtl/dpd_lane.sv
module dpd_lane
  import dpd_codec_pkg::*;
(
  input  logic [DEC_W-1:0] dec_in,
  input  logic [GRP_W-1:0] grp_in,
  output logic [GRP_W-1:0] grp_out,
  output logic [DEC_W-1:0] dec_out
);

  assign grp_out = declet_expand(dec_in);
  assign dec_out = group_compress(grp_in);

endmodule

// File: rtl/dpd_word_map.sv
module dpd_word_map
  import dpd_codec_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int LANES  = 2
) (
  input  logic              dir_sel,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);

  localparam int HALVES = WORD_W / HALF_W;
  localparam int NFIELD = HALVES * LANES;

  logic [GRP_W-1:0] lane_grp [NFIELD];
  logic [DEC_W-1:0] lane_dec [NFIELD];
  logic [WORD_W-1:0] exp_word, cmp_word, used_mask;
  logic unused_in_bits;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int DOFF = h * HALF_W + l * DEC_W;
      localparam int GOFF = h * HALF_W + l * GRP_W;
      dpd_lane u_lane (
        .dec_in (word_in[DOFF +: DEC_W]),
        .grp_in (word_in[GOFF +: GRP_W]),
        .grp_out(lane_grp[h * LANES + l]),
        .dec_out(lane_dec[h * LANES + l])
      );
    end
  end

  always_comb begin
    exp_word  = '0;
    cmp_word  = '0;
    used_mask = '0;
    for (int i = 0; i < NFIELD; i++) begin
      exp_word[(i / LANES) * HALF_W + (i % LANES) * GRP_W +: GRP_W] = lane_grp[i];
      cmp_word[(i / LANES) * HALF_W + (i % LANES) * DEC_W +: DEC_W] = lane_dec[i];
      used_mask[(i / LANES) * HALF_W + (i % LANES) * GRP_W +: GRP_W] = '1;
    end
  end

  // input bits outside every field are deliberately dropped
  assign unused_in_bits = ^(word_in & ~used_mask);

  assign word_out = (dpd_dir_e'(dir_sel) == DIR_COMPRESS) ? cmp_word : exp_word;

endmodule

// File: rtl/dpd_out_stage.sv
module dpd_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take, drain;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;
  assign drain    = out_valid & out_ready & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: rtl/dpd_codec.sv
module dpd_codec
  import dpd_codec_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dir,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);

  function automatic logic [WORD_W-1:0] calc_field_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int h = 0; h < WORD_W / HALF_W; h++)
      for (int l = 0; l < LANES; l++)
        m[h * HALF_W + l * GRP_W +: GRP_W] = '1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FIELD_MASK = calc_field_mask();

  logic [WORD_W-1:0] conv_word;
  logic              accept;

  dpd_word_map #(
    .WORD_W(WORD_W),
    .HALF_W(HALF_W),
    .LANES (LANES)
  ) u_map (
    .dir_sel (in_dir),
    .word_in (in_word),
    .word_out(conv_word)
  );

  dpd_out_stage #(
    .W(WORD_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (conv_word),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_word)
  );

  assign accept = in_valid & in_ready;

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word & ~FIELD_MASK) == '0);

  p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_dir |=> out_word[8] == $past(in_word[7]) &&
                          out_word[4] == $past(in_word[4]) &&
                          out_word[0] == $past(in_word[0]));

  p_passthru_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_dir |=> out_word[7] == $past(in_word[8]) &&
                         out_word[4] == $past(in_word[4]) &&
                         out_word[0] == $past(in_word[0]));

  p_flag_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_dir |=> out_word[3] == $past(in_word[11] | in_word[7] | in_word[3]));

endmodule

// File: tb/dpd_codec_bench.sv
`timescale 1ns/1ps
module dpd_codec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dpd_codec u_dpd_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  // table form of the declet code, written per indicator case
  function automatic logic [11:0] ref_expand(input logic [9:0] x);
    logic [3:0] d2, d1, d0;
    logic p, q, r, s, t, u, w, y;
    {p, q, r, s, t, u} = x[9:4];
    w = x[2]; y = x[0];
    d2 = {1'b0, p, q, r}; d1 = {1'b0, s, t, u}; d0 = {1'b0, x[2:0]};
    if (x[3]) begin
      case (x[2:1])
        2'b00: d0 = {3'b100, y};
        2'b01: begin d1 = {3'b100, u}; d0 = {1'b0, s, t, y}; end
        2'b10: begin d2 = {3'b100, r}; d0 = {1'b0, p, q, y}; end
        default: case ({s, t})
          2'b00: begin d2 = {3'b100, r}; d1 = {3'b100, u}; d0 = {1'b0, p, q, y}; end
          2'b01: begin d2 = {3'b100, r}; d1 = {1'b0, p, q, u}; d0 = {3'b100, y}; end
          2'b10: begin d1 = {3'b100, u}; d0 = {3'b100, y}; end
          default: begin d2 = {3'b100, r}; d1 = {3'b100, u}; d0 = {3'b100, y}; end
        endcase
      endcase
    end
    if (w && !x[3]) d0 = {1'b0, x[2:0]};
    return {d2, d1, d0};
  endfunction

  function automatic logic [9:0] ref_compress(input logic [11:0] g);
    logic a, b, c, d, e, f, h, i, j, k, m, gg;
    {a, b, c, d} = g[11:8];
    {e, f, gg, h} = g[7:4];
    {i, j, k, m} = g[3:0];
    case ({a, e, i})
      3'b000: return {b, c, d, f, gg, h, 1'b0, j, k, m};
      3'b001: return {b, c, d, f, gg, h, 3'b100, m};
      3'b010: return {b, c, d, j, k, h, 3'b101, m};
      3'b011: return {b, c, d, 2'b10, h, 3'b111, m};
      3'b100: return {j, k, d, f, gg, h, 3'b110, m};
      3'b101: return {f, gg, d, 2'b01, h, 3'b111, m};
      3'b110: return {j, k, d, 2'b00, h, 3'b111, m};
      default: return {2'b00, d, 2'b11, h, 3'b111, m};
    endcase
  endfunction

  function automatic logic [63:0] ref_word(input logic dir, input logic [63:0] w);
    logic [63:0] r = '0;
    for (int f = 0; f < 4; f++) begin
      int base = (f / 2) * 32;
      int dpos = base + (f % 2) * 10;
      int gpos = base + (f % 2) * 12;
      if (!dir) r[gpos +: 12] = ref_expand(w[dpos +: 10]);
      else      r[dpos +: 10] = ref_compress(w[gpos +: 12]);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operand through an idle unit; result sampled one cycle later (R7)
  task automatic xfer(input logic dir, input logic [63:0] w, input string req);
    logic [63:0] e;
    e = ref_word(dir, w);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_word = w; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_word === e, req, out_word, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [63:0] w;
    logic [63:0] held;
    void'($urandom(32'h1D5C0DE));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_word === 64'd0 && in_ready === 1'b1,
          "R1 reset", {62'd0, out_valid, in_ready} | out_word, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_word === 64'd0, "R1 after release", out_word, 64'd0);

    // directed corners
    xfer(1'b0, 64'd0, "R2 zero");
    xfer(1'b0, '1, "R2 R5 R6 all ones");
    xfer(1'b1, '1, "R3 R5 R6 all ones");
    xfer(1'b1, 64'h0000_0999_0000_0999, "R3 nines");
    xfer(1'b0, 64'h0000_00FF_0000_00FF, "R2 canonical 999");
    xfer(1'b1, 64'h0000_0000_0000_0800, "R10 top bit a");
    check(out_word[3] === 1'b1, "R10 indicator", {63'd0, out_word[3]}, 64'd1);
    xfer(1'b1, 64'h0000_0000_0000_0111, "R4 low bits");
    check(out_word[7] === 1'b1 && out_word[4] === 1'b1 && out_word[0] === 1'b1,
          "R4 pass-through", out_word, 64'h91);
    xfer(1'b0, 64'hFFF0_0000_FFF0_0000, "R5 garbage only");

    // exhaustive declet sweep (R2 R6), junk in unused bits for R5
    for (int k = 0; k < 1024; k++) begin
      w = {$urandom(), $urandom()};
      w[9:0]   = k[9:0];
      w[19:10] = k[9:0] ^ 10'h2AA;
      w[41:32] = ~k[9:0];
      w[51:42] = 10'((k * 37 + 11) & 1023);
      xfer(1'b0, w, "R2 R5 R6 declet sweep");
    end

    // exhaustive group sweep (R3 R6 R10)
    for (int k = 0; k < 4096; k++) begin
      w = {$urandom(), $urandom()};
      w[11:0]  = k[11:0];
      w[23:12] = k[11:0] ^ 12'hA5C;
      w[43:32] = ~k[11:0];
      w[55:44] = 12'((k * 1013 + 7) & 4095);
      xfer(1'b1, w, "R3 R5 R6 R10 group sweep");
    end

    // random words in both directions
    for (int k = 0; k < 400; k++) begin
      w = {$urandom(), $urandom()};
      xfer(1'(k & 1), w, "R2 R3 R5 random");
    end

    // backpressure: R8 hold, R9 stall and drain
    w = 64'h0123_4567_89AB_CDEF;
    held = ref_word(1'b0, w);
    @(negedge clk);
    in_valid = 1'b1; in_dir = 1'b0; in_word = w; out_ready = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b1 && out_word === held, "R7 stalled result", out_word, held);
    in_dir = 1'b1; in_word = 64'hFFFF_FFFF_FFFF_FFFF;
    check(in_ready === 1'b0, "R9 in_ready low", {63'd0, in_ready}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_word === held, "R8 hold", out_word, held);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 stalled operand dropped", {63'd0, out_valid}, 64'd0);
    check(out_word === held, "R9 no overwrite", out_word, held);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule